// File: doc/BRIEF.md
# Flash Query and Identifier Responder

This block produces the read data a parallel flash bank returns while it is in query mode or in identifier mode. The bank is several identical flash devices placed side by side on one data bus. A read request carries a bus byte address and an access size. The block turns the address into a per-device table index, using the bank width, the configured device width and the device's widest native width. It then looks up either a byte of the query table or a manufacturer/device code, and copies the per-device answer into every device slot of the bank. An access wider than the bank is served by several lookups in parallel, one for each bank-wide field of the response.

Which lookup is used comes from the plain `mode` input, which is sampled when a request is accepted. Entering and leaving these modes is the job of the command logic outside this block. Requests come in and responses go out over valid/ready handshakes. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. Its response is registered and shows up as `rsp_valid` on the next cycle. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds and no new request is taken.

Top module: `flash_qid_responder`

## Requirements
- R1: A request accepted at a clock edge gives `rsp_valid` high after that edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_valid` hold, and `req_ready` is low. Responses leave in the order their requests were accepted.
- R2: The table index is the lookup byte offset shifted right by log2(BANK_W) + log2(MAX_DEV_W) − log2(DEV_W). With the default widths (bank 2, device 1, native 2) this shift is 2.
- R3: In query mode (`mode` = 2'b01) the table returns these values, and zero at every other index:
  - 0x51, 0x52, 0x59 at indices 0x10, 0x11, 0x12;
  - 0x01 at 0x13 and 0x31 at 0x15;
  - the buffer exponent at 0x2A: 8 for a one-byte bank, 11 otherwise;
  - 0x01 at 0x2C;
  - blocks-per-device minus one at 0x2D (low byte) and 0x2E (high byte);
  - sector length / 256 at 0x2F (low byte) and 0x30 (high byte);
  - 0x50, 0x52, 0x49, 0x31, 0x30 at 0x31 through 0x35.
- R4: A query index of 0x52 or more returns zero.
- R5: When DEV_W is smaller than MAX_DEV_W, only byte-wide devices are served. Each byte carries the query byte, repeated rather than padded with zero. Any other narrow-mode combination returns zero.
- R6: The per-device answer is copied into every DEV_W-byte slot of a bank-wide field.
- R7: `req_size` selects 1, 2 or 4 bytes (codes 0, 1, 2; code 3 acts as 4 bytes). Field k, starting at byte k·BANK_W, is looked up at `req_addr` + k·BANK_W, modulo the address width. Bytes at or above the access size read zero.
- R8: In identifier mode (`mode` = 2'b10) the low 8 bits of the index choose the answer: 0 gives MFR_CODE, 1 gives DEVICE_CODE, and any other value gives zero. The codes are cut to, or zero-extended to, DEV_W bytes.
- R9: With `mode` at 2'b00 or 2'b11 the response data is zero. The mode used is the one present when the request is accepted.
- R10: After reset `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 01 query, 10 identifier, other values idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Bus byte address |
| req_size | input | 2 | log2 of the access size in bytes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | ACC_B*8 | Response data |

## Verification
The hardest case is a single edge that does two things: it drains the held response and it accepts the next request, while `mode` switches to a different lookup at that same edge. The bench provokes this case by sweeping every address up to past the end of the table, for every size and every mode. The mode rotates on each request, and the consumer ready follows a pseudo-random pattern, so a drain and an accept often land on the same edge. Every response is popped from an ordered scoreboard of values that the bench computes from the requirements. A stalled response must also stay unchanged until it is taken.

// File: rtl/qid_pkg.sv
package qid_pkg;
  typedef enum logic [1:0] {
    QM_OFF   = 2'b00,
    QM_QUERY = 2'b01,
    QM_IDENT = 2'b10,
    QM_RSVD  = 2'b11
  } qmode_e;

  localparam int unsigned QTAB_LEN = 82;
endpackage

// File: rtl/qid_table.sv
module qid_table
  import qid_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_W     = 2,
  parameter int DEV_W      = 1,
  parameter int SECTOR_LEN = 65536,
  parameter int BLOCKS     = 32
) (
  input  logic [ADDR_W-1:0] idx,
  output logic [7:0]        val
);
  localparam int NDEV = BANK_W / DEV_W;
  localparam int BPD  = BLOCKS / NDEV;
  localparam logic [7:0]  BUF_EXP = (BANK_W == 1) ? 8'd8 : 8'd11;
  localparam logic [15:0] BPD_M1  = 16'(BPD - 1);
  localparam logic [15:0] SEC_DIV = 16'(SECTOR_LEN / 256);

  always_comb begin
    val = 8'h00;
    if (idx < ADDR_W'(QTAB_LEN)) begin
      case (idx[6:0])
        7'h10: val = 8'h51;
        7'h11: val = 8'h52;
        7'h12: val = 8'h59;
        7'h13: val = 8'h01;
        7'h15: val = 8'h31;
        7'h2A: val = BUF_EXP;
        7'h2C: val = 8'h01;
        7'h2D: val = BPD_M1[7:0];
        7'h2E: val = BPD_M1[15:8];
        7'h2F: val = SEC_DIV[7:0];
        7'h30: val = SEC_DIV[15:8];
        7'h31: val = 8'h50;
        7'h32: val = 8'h52;
        7'h33: val = 8'h49;
        7'h34: val = 8'h31;
        7'h35: val = 8'h30;
        default: val = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/qid_lane.sv
module qid_lane
  import qid_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          BANK_W      = 2,
  parameter int          DEV_W       = 1,
  parameter int          MAX_DEV_W   = 2,
  parameter int          SECTOR_LEN  = 65536,
  parameter int          BLOCKS      = 32,
  parameter logic [15:0] MFR_CODE    = 16'h0089,
  parameter logic [15:0] DEVICE_CODE = 16'h8918
) (
  input  qmode_e              mode,
  input  logic [ADDR_W-1:0]   offset,
  output logic [BANK_W*8-1:0] val
);
  localparam int SH     = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
  localparam int NDEV   = BANK_W / DEV_W;
  localparam int SLOT_W = DEV_W * 8;
  localparam bit NARROW    = (DEV_W < MAX_DEV_W);
  localparam bit NARROW_OK = (DEV_W == 1) && (BANK_W <= 4);

  logic [ADDR_W-1:0] idx;
  logic [7:0]        qbyte;
  logic [31:0]       code32;
  logic [SLOT_W-1:0] slot;

  assign idx = offset >> SH;

  qid_table #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W),
    .SECTOR_LEN(SECTOR_LEN), .BLOCKS(BLOCKS)
  ) u_tab (
    .idx(idx),
    .val(qbyte)
  );

  always_comb begin
    code32 = 32'h0;
    if (idx[7:0] == 8'h00)      code32 = {16'h0, MFR_CODE};
    else if (idx[7:0] == 8'h01) code32 = {16'h0, DEVICE_CODE};
  end

  always_comb begin
    slot = '0;
    case (mode)
      QM_QUERY: begin
        if (!NARROW)        slot = SLOT_W'(qbyte);
        else if (NARROW_OK) slot = {DEV_W{qbyte}};
      end
      QM_IDENT: slot = code32[SLOT_W-1:0];
      default:  slot = '0;
    endcase
  end

  for (genvar j = 0; j < NDEV; j++) begin : g_rep
    assign val[j*SLOT_W +: SLOT_W] = slot;
  end
endmodule

// File: rtl/flash_qid_responder.sv
module flash_qid_responder
  import qid_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          ACC_B       = 4,
  parameter int          BANK_W      = 2,
  parameter int          DEV_W       = 1,
  parameter int          MAX_DEV_W   = 2,
  parameter int          SECTOR_LEN  = 65536,
  parameter int          BLOCKS      = 32,
  parameter logic [15:0] MFR_CODE    = 16'h0089,
  parameter logic [15:0] DEVICE_CODE = 16'h8918
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ACC_B*8-1:0] rsp_data
);
  localparam int DATA_W = ACC_B * 8;
  localparam int NLANE  = (ACC_B > BANK_W) ? ACC_B / BANK_W : 1;
  localparam int LG_ACC = $clog2(ACC_B);
  localparam int LANE_W = BANK_W * 8;

  qmode_e                   qm;
  logic [NLANE*LANE_W-1:0]  lanes;
  logic [DATA_W-1:0]        next_data;
  int unsigned              acc_lg;
  int unsigned              nbytes;
  logic                     fire;

  assign qm = qmode_e'(mode);

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    qid_lane #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W),
      .SECTOR_LEN(SECTOR_LEN), .BLOCKS(BLOCKS),
      .MFR_CODE(MFR_CODE), .DEVICE_CODE(DEVICE_CODE)
    ) u_lane (
      .mode(qm),
      .offset(req_addr + ADDR_W'(k * BANK_W)),
      .val(lanes[k*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    acc_lg = (32'(req_size) > LG_ACC) ? LG_ACC : 32'(req_size);
    nbytes = 32'd1 << acc_lg;
  end

  for (genvar j = 0; j < ACC_B; j++) begin : g_mask
    if (j < NLANE * BANK_W) begin : g_live
      assign next_data[j*8 +: 8] = (j < nbytes) ? lanes[j*8 +: 8] : 8'h00;
    end else begin : g_pad
      assign next_data[j*8 +: 8] = 8'h00;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= next_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  a_r1_fire: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (mode == 2'b00 || mode == 2'b11) |=> rsp_data == '0);
  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_size == 2'd0 |=> (rsp_data >> 8) == '0);
  a_r10_free: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> req_ready);
endmodule

// File: tb/sim_flash_qid_responder.sv
module sim_flash_qid_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int got = 0;
  bit run_mon = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  flash_qid_responder u0 (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] qbyte(input int idx);
    if (idx >= 82) return 8'h00;
    case (idx)
      'h10: return 8'h51;  'h11: return 8'h52;  'h12: return 8'h59;
      'h13: return 8'h01;  'h15: return 8'h31;  'h2A: return 8'h0B;
      'h2C: return 8'h01;  'h2D: return 8'h0F;  'h2E: return 8'h00;
      'h2F: return 8'h00;  'h30: return 8'h01;  'h31: return 8'h50;
      'h32: return 8'h52;  'h33: return 8'h49;  'h34: return 8'h31;
      'h35: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] expect_val(input logic [1:0] m, input int addr, input int sz);
    logic [31:0] r = 32'h0;
    int n = 1 << sz;
    for (int j = 0; j < n; j++) begin
      int off = (addr + 2 * (j / 2)) % 65536;
      int idx = off >> 2;
      logic [7:0] b = 8'h00;
      if (m == 2'b01) b = qbyte(idx);
      else if (m == 2'b10) b = ((idx % 256) == 0) ? 8'h89 : ((idx % 256) == 1) ? 8'h18 : 8'h00;
      r[j*8 +: 8] = b;
    end
    return r;
  endfunction

  function automatic string pick_tag(input logic [1:0] m, input int addr, input int sz);
    if (m == 2'b00 || m == 2'b11) return "R9";
    if (m == 2'b10) return "R8 R6";
    if (((addr >> 2) >= 82) || (((addr + 2) >> 2) >= 82 && sz == 2)) return "R4";
    if (sz == 2) return "R7 R2 R3";
    return "R2 R3 R5 R6";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] m, input int addr, input int sz);
    @(negedge clk);
    mode = m;
    req_addr = 16'(addr);
    req_size = 2'(sz);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(expect_val(m, addr, sz));
    tag_q.push_back(pick_tag(m, addr, sz));
    sent++;
  endtask

  // response monitor with pseudo-random back-pressure
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic        stalled = 1'b0;
    logic [31:0] held = '0;
    forever begin
      @(negedge clk);
      if (run_mon) begin
        if (stalled) check(rsp_valid && rsp_data == held, "R1 hold", rsp_data, held);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rsp_ready = lfsr[0] | lfsr[1];
        if (rsp_valid && rsp_ready) begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e, t, rsp_data, e);
          got++;
        end
        stalled = rsp_valid && !rsp_ready;
        held = rsp_data;
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: idle after reset
    check(!rsp_valid, "R10 valid", {31'h0, rsp_valid}, 32'h0);
    check(req_ready, "R10 ready", {31'h0, req_ready}, 32'h1);
    run_mon = 1'b1;
    // R1: latency of one cycle
    send(2'b01, 'h40, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid, "R1 latency", {31'h0, rsp_valid}, 32'h1);
    // R8: index wraps in its low 8 bits, and lane address wrap (R7)
    send(2'b10, 'h400, 1);
    send(2'b10, 'h404, 2);
    send(2'b01, 'hFFFC, 2);
    send(2'b10, 'hFFFE, 2);
    // sweep: every address, size and mode, rotating the mode on each request
    for (int a = 0; a < 'h188; a++) begin
      for (int s = 0; s < 3; s++) begin
        for (int m = 0; m < 4; m++) begin
          send(2'((m + a + s) % 4), a, s);
          if (((a + m) % 7) == 0) begin
            @(negedge clk);
            req_valid = 1'b0;
          end
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    while (got < sent) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule